// File: doc/BRIEF.md
# Paired Register File for an 8-bit Datapath

This block is the architectural register storage of a small 8-bit processor. It keeps an accumulator, a flag byte, six general byte registers (B, C, D, E, H, L) and a 16-bit stack pointer. Two combinational byte read ports and one byte write port serve ordinary byte instructions. A 16-bit read port and a 16-bit write port serve the pairs BC, DE, HL, SP and AF, for example for stack transfers or for loading a pair from an immediate.

A pair-operation input performs the 16-bit work in one clock:
- increment or decrement of a pair;
- add of a pair into HL, which reports only a carry;
- swap of DE with HL;
- copy of HL into SP.

The HL, BC and DE pairs and the stack pointer are driven out at all times, so that a memory stage can use them as indirect addresses without spending a read port.

All writes take effect at the rising clock edge. All reads show the stored state.

Top module: `pair_regfile`

## Requirements
- R1: While reset (active low) is held, and at the first edge after it, every register is zero. All outputs then read zero.
- R2: Byte register codes are B=0, C=1, D=2, E=3, H=4, L=5, F(flags)=6, A=7. A byte write with the enable set stores the data at the clock edge. Both byte read ports return the addressed register combinationally.
- R3: Pair codes for the pair ports are BC=0, DE=1, HL=2, SP=3, AF=4. The first-named register is the high byte, and in AF the accumulator is the high byte. A pair write stores all 16 bits at the edge. A pair read returns them combinationally.
- R4: When a byte write and a pair write target the same register in one cycle, the register takes the pair write's byte. A byte write to a register outside the written pair still takes effect.
- R5: Operation code 1 increments and code 2 decrements the pair selected by the operation pair code (BC=0, DE=1, HL=2, SP=3). Both wrap modulo 65536 and leave the flag byte unchanged.
- R6: Operation code 3 writes HL + selected pair into HL. The pair may be HL itself, which doubles it. Flag bit 0 (carry) takes the carry out of bit 15. Flag bits 7..1 keep their value.
- R7: Operation code 4 exchanges the full contents of DE and HL in one cycle.
- R8: Operation code 5 copies HL into SP and leaves HL unchanged.
- R9: A pair operation takes priority over both write ports for each register bit it changes.
- R10: The outputs for BC, DE, HL, SP, A and flags always equal the stored contents.
- R11: A pair write with a code of 5, 6 or 7 changes no register. An operation code of 0, 6 or 7 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rda_sel | input | 3 | Byte read port A register code |
| rda_data | output | 8 | Byte read port A data |
| rdb_sel | input | 3 | Byte read port B register code |
| rdb_data | output | 8 | Byte read port B data |
| bw_en | input | 1 | Byte write enable |
| bw_sel | input | 3 | Byte write register code |
| bw_data | input | 8 | Byte write data |
| pr_sel | input | 3 | Pair read code |
| pr_data | output | 16 | Pair read data |
| pw_en | input | 1 | Pair write enable |
| pw_sel | input | 3 | Pair write code |
| pw_data | input | 16 | Pair write data |
| op | input | 3 | Pair operation code |
| op_pair | input | 2 | Pair selected by the operation |
| bc_addr | output | 16 | BC contents |
| de_addr | output | 16 | DE contents |
| hl_addr | output | 16 | HL contents |
| sp_val | output | 16 | Stack pointer contents |
| acc | output | 8 | Accumulator contents |
| flags | output | 8 | Flag byte contents |

## Verification
The hardest situations to reach are collisions, where two or three sources update the same register in one edge. Examples are a byte write inside a pair being written, or a pair operation racing a pair write. The carry of the 16-bit add must also land while the upper flag bits are held.

The stimulus first loads known, distinct patterns through the pair port. It then drives the colliding requests together in a single cycle and reads every affected register back through the ports. The add cases use HL = 0x8000 and BC = 0x8001 to force a carry out of bit 15, and HL + HL to show doubling with no carry.

// File: rtl/pair_regfile.sv
module pair_regfile (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  rda_sel,
  output logic [7:0]  rda_data,
  input  logic [2:0]  rdb_sel,
  output logic [7:0]  rdb_data,
  input  logic        bw_en,
  input  logic [2:0]  bw_sel,
  input  logic [7:0]  bw_data,
  input  logic [2:0]  pr_sel,
  output logic [15:0] pr_data,
  input  logic        pw_en,
  input  logic [2:0]  pw_sel,
  input  logic [15:0] pw_data,
  input  logic [2:0]  op,
  input  logic [1:0]  op_pair,
  output logic [15:0] bc_addr,
  output logic [15:0] de_addr,
  output logic [15:0] hl_addr,
  output logic [15:0] sp_val,
  output logic [7:0]  acc,
  output logic [7:0]  flags
);
  localparam logic [2:0] OP_INC = 3'd1, OP_DEC = 3'd2, OP_ADD = 3'd3,
                         OP_XCH = 3'd4, OP_SPHL = 3'd5;

  logic [7:0]  r   [8];
  logic [7:0]  nxt [8];
  logic [15:0] sp, nsp;
  logic [15:0] src, step_v;
  logic [16:0] sum_v;

  assign bc_addr = {r[0], r[1]};
  assign de_addr = {r[2], r[3]};
  assign hl_addr = {r[4], r[5]};
  assign sp_val  = sp;
  assign acc     = r[7];
  assign flags   = r[6];

  assign rda_data = r[rda_sel];
  assign rdb_data = r[rdb_sel];

  always_comb begin
    case (pr_sel)
      3'd0:    pr_data = bc_addr;
      3'd1:    pr_data = de_addr;
      3'd2:    pr_data = hl_addr;
      3'd3:    pr_data = sp;
      3'd4:    pr_data = {r[7], r[6]};
      default: pr_data = 16'h0000;
    endcase
  end

  always_comb begin
    case (op_pair)
      2'd0:    src = bc_addr;
      2'd1:    src = de_addr;
      2'd2:    src = hl_addr;
      default: src = sp;
    endcase
  end

  assign step_v = (op == OP_DEC) ? src - 16'd1 : src + 16'd1;
  assign sum_v  = {1'b0, hl_addr} + {1'b0, src};

  always_comb begin
    for (int i = 0; i < 8; i++) nxt[i] = r[i];
    nsp = sp;
    if (bw_en) nxt[bw_sel] = bw_data;
    if (pw_en) begin
      case (pw_sel)
        3'd0: begin nxt[0] = pw_data[15:8]; nxt[1] = pw_data[7:0]; end
        3'd1: begin nxt[2] = pw_data[15:8]; nxt[3] = pw_data[7:0]; end
        3'd2: begin nxt[4] = pw_data[15:8]; nxt[5] = pw_data[7:0]; end
        3'd3: nsp = pw_data;
        3'd4: begin nxt[7] = pw_data[15:8]; nxt[6] = pw_data[7:0]; end
        default: ;
      endcase
    end
    case (op)
      OP_INC, OP_DEC: begin
        case (op_pair)
          2'd0: begin nxt[0] = step_v[15:8]; nxt[1] = step_v[7:0]; end
          2'd1: begin nxt[2] = step_v[15:8]; nxt[3] = step_v[7:0]; end
          2'd2: begin nxt[4] = step_v[15:8]; nxt[5] = step_v[7:0]; end
          default: nsp = step_v;
        endcase
      end
      OP_ADD: begin
        nxt[4]    = sum_v[15:8];
        nxt[5]    = sum_v[7:0];
        nxt[6][0] = sum_v[16];
      end
      OP_XCH: begin
        nxt[2] = r[4]; nxt[3] = r[5];
        nxt[4] = r[2]; nxt[5] = r[3];
      end
      OP_SPHL: nsp = hl_addr;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) r[i] <= 8'h00;
      sp <= 16'h0000;
    end else begin
      for (int i = 0; i < 8; i++) r[i] <= nxt[i];
      sp <= nsp;
    end
  end
endmodule

// File: rtl/pair_regfile_chk.sv
module pair_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bw_en,
  input logic [2:0]  bw_sel,
  input logic [7:0]  bw_data,
  input logic        pw_en,
  input logic [2:0]  pw_sel,
  input logic [15:0] pw_data,
  input logic [2:0]  op,
  input logic [1:0]  op_pair,
  input logic [15:0] bc_addr,
  input logic [15:0] de_addr,
  input logic [15:0] hl_addr,
  input logic [15:0] sp_val,
  input logic [7:0]  acc,
  input logic [7:0]  flags
);
  logic [15:0] opnd;
  assign opnd = (op_pair == 2'd0) ? bc_addr :
                (op_pair == 2'd1) ? de_addr :
                (op_pair == 2'd2) ? hl_addr : sp_val;

  logic f_written;
  assign f_written = (bw_en && bw_sel == 3'd6) || (pw_en && pw_sel == 3'd4);

  a_r2_acc_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bw_en && bw_sel == 3'd7 && !(pw_en && pw_sel == 3'd4)) |=> acc == $past(bw_data));

  a_r4_pair_beats_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_en && pw_sel == 3'd2 && op == 3'd0) |=> hl_addr == $past(pw_data));

  a_r5_inc_bc: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd1 && op_pair == 2'd0) |=> bc_addr == $past(bc_addr) + 16'd1);

  a_r5_dec_sp: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd2 && op_pair == 2'd3) |=> sp_val == $past(sp_val) - 16'd1);

  a_r5_step_flags: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == 3'd1 || op == 3'd2) && !f_written) |=> $stable(flags));

  a_r6_add_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd3) |=> {flags[0], hl_addr} == $past({1'b0, hl_addr} + {1'b0, opnd}));

  a_r6_add_upper_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd3 && !f_written) |=> flags[7:1] == $past(flags[7:1]));

  a_r7_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd4) |=> (de_addr == $past(hl_addr)) && (hl_addr == $past(de_addr)));

  a_r8_sphl: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd5) |=> sp_val == $past(hl_addr));

  a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!bw_en && (!pw_en || pw_sel > 3'd4) && (op == 3'd0 || op > 3'd5))
      |=> $stable(bc_addr) && $stable(de_addr) && $stable(hl_addr)
          && $stable(sp_val) && $stable(acc) && $stable(flags));
endmodule

bind pair_regfile pair_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bw_en(bw_en), .bw_sel(bw_sel), .bw_data(bw_data),
  .pw_en(pw_en), .pw_sel(pw_sel), .pw_data(pw_data), .op(op), .op_pair(op_pair),
  .bc_addr(bc_addr), .de_addr(de_addr), .hl_addr(hl_addr), .sp_val(sp_val),
  .acc(acc), .flags(flags)
);

// File: tb/sim_pair_regfile.sv
module sim_pair_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  rda_sel = '0, rdb_sel = '0, bw_sel = '0, pw_sel = '0, pr_sel = '0, op = '0;
  logic [1:0]  op_pair = '0;
  logic        bw_en = 1'b0, pw_en = 1'b0;
  logic [7:0]  bw_data = '0;
  logic [15:0] pw_data = '0;
  logic [7:0]  rda_data, rdb_data, acc, flags;
  logic [15:0] pr_data, bc_addr, de_addr, hl_addr, sp_val;
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pair_regfile u0 (
    .clk(clk), .rst_n(rst_n), .rda_sel(rda_sel), .rda_data(rda_data),
    .rdb_sel(rdb_sel), .rdb_data(rdb_data), .bw_en(bw_en), .bw_sel(bw_sel),
    .bw_data(bw_data), .pr_sel(pr_sel), .pr_data(pr_data), .pw_en(pw_en),
    .pw_sel(pw_sel), .pw_data(pw_data), .op(op), .op_pair(op_pair),
    .bc_addr(bc_addr), .de_addr(de_addr), .hl_addr(hl_addr), .sp_val(sp_val),
    .acc(acc), .flags(flags));

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic bwrite(input logic [2:0] s, input logic [7:0] d);
    bw_en = 1; bw_sel = s; bw_data = d; tick(); bw_en = 0;
  endtask

  task automatic pwrite(input logic [2:0] s, input logic [15:0] d);
    pw_en = 1; pw_sel = s; pw_data = d; tick(); pw_en = 0;
  endtask

  task automatic do_op(input logic [2:0] o, input logic [1:0] p);
    op = o; op_pair = p; tick(); op = 0;
  endtask

  task automatic t_reset();
    chk("R1 bc", bc_addr, 0); chk("R1 de", de_addr, 0); chk("R1 hl", hl_addr, 0);
    chk("R1 sp", sp_val, 0); chk("R1 acc", {8'h0, acc}, 0); chk("R1 flags", {8'h0, flags}, 0);
  endtask

  task automatic t_bytes();
    for (int i = 0; i < 8; i++) bwrite(3'(i), 8'(8'h11 * (i + 1)));
    for (int i = 0; i < 8; i++) begin
      rda_sel = 3'(i); rdb_sel = 3'(7 - i); #1;
      chk("R2 port a", {8'h0, rda_data}, 16'(8'h11 * (i + 1)));
      chk("R2 port b", {8'h0, rdb_data}, 16'(8'h11 * (8 - i)));
    end
    chk("R10 bc", bc_addr, 16'h1122); chk("R10 de", de_addr, 16'h3344);
    chk("R10 hl", hl_addr, 16'h5566);
    chk("R10 acc", {8'h0, acc}, 16'h0088); chk("R10 flags", {8'h0, flags}, 16'h0077);
  endtask

  task automatic t_pairs();
    pwrite(0, 16'hA1B2); pwrite(1, 16'hC3D4); pwrite(2, 16'hE5F6);
    pwrite(3, 16'h1357); pwrite(4, 16'h9AC4);
    for (int i = 0; i < 5; i++) begin
      pr_sel = 3'(i); #1;
      case (i)
        0: chk("R3 read bc", pr_data, 16'hA1B2);
        1: chk("R3 read de", pr_data, 16'hC3D4);
        2: chk("R3 read hl", pr_data, 16'hE5F6);
        3: chk("R3 read sp", pr_data, 16'h1357);
        default: chk("R3 read af", pr_data, 16'h9AC4);
      endcase
    end
    rda_sel = 0; rdb_sel = 5; #1;
    chk("R3 B high", {8'h0, rda_data}, 16'h00A1); chk("R3 L low", {8'h0, rdb_data}, 16'h00F6);
    chk("R3 acc high", {8'h0, acc}, 16'h009A);
    pwrite(5, 16'hFFFF); pwrite(7, 16'h0000);
    chk("R11 bc", bc_addr, 16'hA1B2); chk("R11 de", de_addr, 16'hC3D4);
    chk("R11 hl", hl_addr, 16'hE5F6); chk("R11 sp", sp_val, 16'h1357);
    chk("R11 af", {acc, flags}, 16'h9AC4);
    do_op(6, 0); do_op(7, 2);
    chk("R11 op idle hl", hl_addr, 16'hE5F6); chk("R11 op idle bc", bc_addr, 16'hA1B2);
  endtask

  task automatic t_conflict();
    bw_en = 1; bw_sel = 0; bw_data = 8'hAA;
    pw_en = 1; pw_sel = 0; pw_data = 16'h5566;
    tick(); bw_en = 0; pw_en = 0;
    chk("R4 same reg", bc_addr, 16'h5566);
    bw_en = 1; bw_sel = 7; bw_data = 8'h3C;
    pw_en = 1; pw_sel = 1; pw_data = 16'h7788;
    tick(); bw_en = 0; pw_en = 0;
    chk("R4 other pair", de_addr, 16'h7788); chk("R4 other byte", {8'h0, acc}, 16'h003C);
  endtask

  task automatic t_incdec();
    pwrite(4, 16'h00D5); pwrite(0, 16'hFFFF); pwrite(3, 16'h0000);
    do_op(1, 0);
    chk("R5 inc wrap", bc_addr, 16'h0000); chk("R5 inc flags", {8'h0, flags}, 16'h00D5);
    do_op(2, 3);
    chk("R5 dec wrap", sp_val, 16'hFFFF); chk("R5 dec flags", {8'h0, flags}, 16'h00D5);
    pwrite(1, 16'h00FF); do_op(1, 1);
    chk("R5 inc carry byte", de_addr, 16'h0100);
    do_op(2, 2); pwrite(2, 16'h1000); do_op(2, 2);
    chk("R5 dec hl", hl_addr, 16'h0FFF);
  endtask

  task automatic t_add();
    pwrite(4, 16'h00C4); pwrite(2, 16'h8000); pwrite(0, 16'h8001);
    do_op(3, 0);
    chk("R6 sum", hl_addr, 16'h0001); chk("R6 carry set", {8'h0, flags}, 16'h00C5);
    pwrite(2, 16'h1234); do_op(3, 2);
    chk("R6 double", hl_addr, 16'h2468); chk("R6 carry clear", {8'h0, flags}, 16'h00C4);
    pwrite(3, 16'h0100); do_op(3, 3);
    chk("R6 add sp", hl_addr, 16'h2568);
  endtask

  task automatic t_swap_sp();
    pwrite(1, 16'hDEAD); pwrite(2, 16'hBEEF);
    do_op(4, 0);
    chk("R7 de", de_addr, 16'hBEEF); chk("R7 hl", hl_addr, 16'hDEAD);
    do_op(5, 0);
    chk("R8 sp", sp_val, 16'hDEAD); chk("R8 hl kept", hl_addr, 16'hDEAD);
  endtask

  task automatic t_prio();
    pwrite(0, 16'h0010);
    op = 1; op_pair = 0; pw_en = 1; pw_sel = 0; pw_data = 16'h4000;
    bw_en = 1; bw_sel = 1; bw_data = 8'h99;
    tick(); op = 0; pw_en = 0; bw_en = 0;
    chk("R9 op wins", bc_addr, 16'h0011);
    pwrite(4, 16'h0000); pwrite(2, 16'hFFFF); pwrite(0, 16'h0001);
    op = 3; op_pair = 0; bw_en = 1; bw_sel = 6; bw_data = 8'hF0;
    tick(); op = 0; bw_en = 0;
    chk("R9 carry over byte write", {8'h0, flags}, 16'h00F1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    t_reset();
    rst_n = 1; tick();
    t_reset();
    t_bytes();
    t_pairs();
    t_conflict();
    t_incdec();
    t_add();
    t_swap_sp();
    t_prio();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule